// File: doc/BRIEF.md
# Robbed-Bit Signaling Extraction Buffer

This block takes the received serial data of a 24-channel T1 stream and lifts the robbed-bit signaling out of it. It samples the last bit of every channel in the signaling frames. It collects those bits into one word per multiframe and keeps the words in a circular store four multiframes deep. It plays them back three multiframes later as a channel-aligned serial signaling stream. Next to the stream it presents the signaling nibble of the current channel, for a later reinsertion stage. Bit, channel and frame counters and a multiframe-start strobe come from the surrounding framer. The block keeps no timing of its own.

Two framing modes are supported. The extended superframe (ESF) carries four signaling bits A, B, C and D per channel. The 12-frame D4 superframe carries only A and B, and repeats them in the output. When the line degrades, the store stops taking new words. This happens on out-of-frame, loss of carrier or a frame slip if automatic freezing is enabled, and at any time through a force input. Once the trouble clears, the store stays frozen for three more multiframe boundaries. Playback never stops during a freeze. The output keeps cycling through the last good words it holds.

Top module: `rbs_sig_buffer`

## Requirements
- R1: In ESF mode (`esf_mode`=1), the bit at `bit_idx`=7 (the channel's last bit) is captured as A in frame index 5, as B in index 11, as C in index 17 and as D in index 23. Frame indices count from 0. No other bit position or frame affects the captured word.
- R2: In ESF mode, `sig_nib` is {A,B,C,D} with A in bit 3. `sig_out` is 0 for `bit_idx` 0 to 3 and carries A, B, C, D at `bit_idx` 4, 5, 6, 7.
- R3: In D4 mode (`esf_mode`=0), A comes from frame index 5 and B from index 11. `sig_nib` is {A,B,A,B}, and the serial lower nibble carries A, B, A, B.
- R4: A word captured during multiframe m is shown on the outputs during multiframe m+3. After reset the store holds zeros.
- R5: For a fixed channel, `sig_nib` changes only across a cycle in which `mf_start` is high.
- R6: With `auto_freeze_en`=1, a high level on `oof`, `carrier_loss` or `slip` raises `freeze_active` and blocks writes to the store. With `auto_freeze_en`=0 these inputs have no effect.
- R7: `force_freeze`=1 raises `freeze_active` and blocks the store write at any boundary it covers, whatever the error inputs are.
- R8: After the last cycle of an enabled error, writes stay blocked and `freeze_active` stays high for the next three multiframe boundaries. A new error during that window restarts the count at three.
- R9: While writes are blocked, the read position still advances at each boundary, so the outputs replay the four stored words in turn.
- R10: During and right after reset, `sig_out`, `sig_nib` and `freeze_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rx_data | input | 1 | Received serial PCM data |
| bit_idx | input | 3 | Bit position in the channel, 0 = first transmitted bit |
| ch_idx | input | 5 | Channel number, 0 to 23 |
| frm_idx | input | 5 | Frame number in the multiframe, from 0 |
| mf_start | input | 1 | High in the first bit cycle of each multiframe |
| esf_mode | input | 1 | 1 = ESF four-bit signaling, 0 = D4 two-bit signaling |
| auto_freeze_en | input | 1 | Enables freezing on line errors |
| force_freeze | input | 1 | Freezes the store unconditionally |
| oof | input | 1 | Out-of-frame indication |
| carrier_loss | input | 1 | Loss-of-carrier indication |
| slip | input | 1 | Frame slip indication |
| sig_out | output | 1 | Serial signaling stream in channel timing |
| sig_nib | output | 4 | Delayed signaling nibble of the current channel, A in bit 3 |
| freeze_active | output | 1 | High while a freeze is in effect |

## Verification
Each multiframe carries a different signaling word per channel, and noise fills every other bit position. A wrong capture frame, a wrong bit position or a wrong delay depth therefore shows up as a mismatched nibble. Separate error multiframes drive out-of-frame, slip and carrier loss. Comparing their outcomes with automatic freezing on and off tells a working gate from an ignored enable. Two errors spaced less than three multiframes apart show whether the hold window restarts. A forced freeze multiframe shows the replay of stored words. The ESF run and the D4 run use the same data pattern, which exposes the A/B duplication and the C/D masking.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int SIG_N       = 4;  // signaling bits per channel (A..D)
  localparam int BITS_PER_CH = 8;
  localparam int BIT_W       = $clog2(BITS_PER_CH);
  localparam int FRM_PER_SIG = 6;  // spacing of signaling frames
  localparam int D4_SIG_N    = 2;  // D4 carries only A and B
  typedef logic [SIG_N-1:0] sig_nib_t;
endpackage

// File: rtl/rbs_capture.sv
// Collects the signaling bits of the running multiframe into a staging word.
module rbs_capture
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5,
  parameter int FRM_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_data,
  input  logic [BIT_W-1:0]        bit_idx,
  input  logic [CH_W-1:0]         ch_idx,
  input  logic [FRM_W-1:0]        frm_idx,
  input  logic                    esf_mode,
  output logic [NUM_CH*SIG_N-1:0] stage_q
);
  localparam logic [BIT_W-1:0] LSB_POS = BIT_W'(BITS_PER_CH - 1);

  logic [NUM_CH*SIG_N-1:0] stage_d;
  logic [SIG_N-1:0]        hit;

  generate
    for (genvar k = 0; k < SIG_N; k++) begin : g_hit
      localparam int CAP_FRM  = FRM_PER_SIG * (k + 1) - 1;
      localparam bit ESF_ONLY = (k >= D4_SIG_N);
      assign hit[k] = (bit_idx == LSB_POS) &&
                      (frm_idx == FRM_W'(CAP_FRM)) &&
                      (esf_mode || !ESF_ONLY);
    end
  endgenerate

  always_comb begin
    stage_d = stage_q;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int k = 0; k < SIG_N; k++) begin
        if (hit[k] && (ch_idx == CH_W'(c))) begin
          stage_d[c*SIG_N + (SIG_N-1-k)] = rx_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/rbs_freeze_ctl.sv
// Freeze decision and post-error hold counter (counts multiframe boundaries).
module rbs_freeze_ctl #(
  parameter int HOLD_MF = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_start,
  input  logic auto_en,
  input  logic force_frz,
  input  logic oof,
  input  logic carrier_loss,
  input  logic slip,
  output logic freeze
);
  localparam int HOLD_W = $clog2(HOLD_MF + 1);

  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              err_hit;

  assign err_hit = auto_en & (oof | carrier_loss | slip);

  always_comb begin
    hold_d = hold_q;
    if (err_hit) begin
      hold_d = HOLD_W'(HOLD_MF);
    end else if (mf_start && (hold_q != '0)) begin
      hold_d = hold_q - HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign freeze = force_frz | err_hit | (hold_q != '0);
endmodule

// File: rtl/rbs_store.sv
// Circular multiframe store; read trails write by SLOTS-1 boundaries.
module rbs_store
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5,
  parameter int SLOTS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mf_start,
  input  logic                    wr_block,
  input  logic [NUM_CH*SIG_N-1:0] stage_q,
  input  logic [CH_W-1:0]         ch_idx,
  output sig_nib_t                rd_nib
);
  localparam int PTR_W = $clog2(SLOTS);
  localparam int WORD_W = NUM_CH * SIG_N;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(SLOTS - 1);
  localparam logic [PTR_W-1:0] RD_START  = PTR_W'(1);

  logic [WORD_W-1:0] slot_q [SLOTS];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic              wr_en;
  logic [WORD_W-1:0] rd_word;

  assign wr_en = mf_start & ~wr_block;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (wr_en)    wp_d = (wp_q == LAST_SLOT) ? '0 : wp_q + PTR_W'(1);
    if (mf_start) rp_d = (rp_q == LAST_SLOT) ? '0 : rp_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= RD_START;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (wp_q == PTR_W'(s)) slot_q[s] <= stage_q;
      end
    end
  end

  assign rd_word = slot_q[rp_q];

  always_comb begin
    rd_nib = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CH_W'(c)) rd_nib = rd_word[c*SIG_N +: SIG_N];
    end
  end
endmodule

// File: rtl/rbs_serializer.sv
// Formats the nibble for the framing mode and places it in channel timing.
module rbs_serializer
  import rbs_pkg::*;
(
  input  logic             esf_mode,
  input  logic [BIT_W-1:0] bit_idx,
  input  sig_nib_t         rd_nib,
  output sig_nib_t         sig_nib,
  output logic             sig_out
);
  always_comb begin
    if (esf_mode) sig_nib = rd_nib;
    else          sig_nib = {rd_nib[3], rd_nib[2], rd_nib[3], rd_nib[2]};
  end

  assign sig_out = bit_idx[BIT_W-1] & sig_nib[2'd3 - bit_idx[1:0]];
endmodule

// File: rtl/rbs_sig_buffer.sv
module rbs_sig_buffer
  import rbs_pkg::*;
#(
  parameter int NUM_CH  = 24,
  parameter int FRM_W   = 5,
  parameter int SLOTS   = 4,
  parameter int HOLD_MF = 3,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_data,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [CH_W-1:0]  ch_idx,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic             mf_start,
  input  logic             esf_mode,
  input  logic             auto_freeze_en,
  input  logic             force_freeze,
  input  logic             oof,
  input  logic             carrier_loss,
  input  logic             slip,
  output logic             sig_out,
  output logic [SIG_N-1:0] sig_nib,
  output logic             freeze_active
);
  logic [NUM_CH*SIG_N-1:0] stage_q;
  sig_nib_t                rd_nib;
  logic                    frz;

  rbs_capture #(.NUM_CH(NUM_CH), .CH_W(CH_W), .FRM_W(FRM_W)) i_capture (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .bit_idx(bit_idx),
    .ch_idx(ch_idx), .frm_idx(frm_idx), .esf_mode(esf_mode), .stage_q(stage_q)
  );

  rbs_freeze_ctl #(.HOLD_MF(HOLD_MF)) i_freeze (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .auto_en(auto_freeze_en),
    .force_frz(force_freeze), .oof(oof), .carrier_loss(carrier_loss),
    .slip(slip), .freeze(frz)
  );

  rbs_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SLOTS(SLOTS)) i_store (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .wr_block(frz),
    .stage_q(stage_q), .ch_idx(ch_idx), .rd_nib(rd_nib)
  );

  rbs_serializer i_ser (
    .esf_mode(esf_mode), .bit_idx(bit_idx), .rd_nib(rd_nib),
    .sig_nib(sig_nib), .sig_out(sig_out)
  );

  assign freeze_active = frz;
endmodule

// File: rtl/rbs_sig_buffer_chk.sv
module rbs_sig_buffer_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      bit_idx,
  input logic [CH_W-1:0] ch_idx,
  input logic            mf_start,
  input logic            esf_mode,
  input logic            auto_freeze_en,
  input logic            force_freeze,
  input logic            oof,
  input logic            carrier_loss,
  input logic            slip,
  input logic            sig_out,
  input logic [3:0]      sig_nib,
  input logic            freeze_active
);
  // R2: upper nibble of each channel slot is quiet
  p_upper_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_idx[2] |-> !sig_out);

  // R3: D4 repeats A,B in both halves of the nibble
  p_d4_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_mode |-> (sig_nib[3:2] == sig_nib[1:0]));

  // R5: nibble only moves across a multiframe boundary
  p_mf_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(mf_start) && $stable(ch_idx) && $stable(esf_mode))
      |-> $stable(sig_nib));

  // R7: forcing always shows as a freeze
  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_freeze |-> freeze_active);

  // R8: an enabled error keeps the freeze up in the following cycle
  p_hold_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_freeze_en && (oof || carrier_loss || slip)) |=> freeze_active);
endmodule

bind rbs_sig_buffer rbs_sig_buffer_chk #(.CH_W(CH_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .ch_idx(ch_idx),
  .mf_start(mf_start), .esf_mode(esf_mode), .auto_freeze_en(auto_freeze_en),
  .force_freeze(force_freeze), .oof(oof), .carrier_loss(carrier_loss),
  .slip(slip), .sig_out(sig_out), .sig_nib(sig_nib),
  .freeze_active(freeze_active)
);

// File: tb/test_rbs_sig_buffer.sv
module test_rbs_sig_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 24;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, rx_data, mf_start, esf_mode;
  logic       auto_freeze_en, force_freeze, oof, carrier_loss, slip;
  logic [2:0] bit_idx;
  logic [4:0] ch_idx, frm_idx;
  logic       sig_out, freeze_active;
  logic [3:0] sig_nib;

  int tests, fails, cycles;
  int slot_m [4][NCH];
  int prev_m [NCH];
  int wp_m, rp_m, hold_m;

  rbs_sig_buffer i_rbs_sig_buffer (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .bit_idx(bit_idx),
    .ch_idx(ch_idx), .frm_idx(frm_idx), .mf_start(mf_start),
    .esf_mode(esf_mode), .auto_freeze_en(auto_freeze_en),
    .force_freeze(force_freeze), .oof(oof), .carrier_loss(carrier_loss),
    .slip(slip), .sig_out(sig_out), .sig_nib(sig_nib),
    .freeze_active(freeze_active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_val(input int k, input int ch);
    return 4'((k*5 + ch*3 + 1) & 15);
  endfunction

  function automatic logic [3:0] fmt(input logic [3:0] v, input bit esf);
    return esf ? v : {v[3], v[2], v[3], v[2]};
  endfunction

  function automatic logic rx_bit(input int k, input int ch, input int frm,
                                  input int b, input bit esf);
    logic [3:0] v;
    v = nib_val(k, ch);
    if (b == 7 && frm == 5)         return v[3];
    if (b == 7 && frm == 11)        return v[2];
    if (esf && b == 7 && frm == 17) return v[1];
    if (esf && b == 7 && frm == 23) return v[0];
    return 1'(((ch*3) + frm + b + k) & 1);
  endfunction

  task automatic do_reset(input bit esf);
    rst_n = 1'b0; rx_data = 0; mf_start = 0; esf_mode = esf;
    auto_freeze_en = 1; force_freeze = 0; oof = 0; carrier_loss = 0; slip = 0;
    bit_idx = 3'd7; ch_idx = 0; frm_idx = 0;
    for (int i = 0; i < 3; i++) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) for (int c = 0; c < NCH; c++) slot_m[s][c] = 0;
    for (int c = 0; c < NCH; c++) prev_m[c] = 0;
    wp_m = 0; rp_m = 1; hold_m = 0;
    #1;
    chk("R10 nibble after reset", int'(sig_nib), 0);
    chk("R10 serial after reset", int'(sig_out), 0);
    chk("R10 freeze after reset", int'(freeze_active), 0);
  endtask

  // one multiframe; ek: 0 none, 1 oof, 2 carrier loss, 3 slip (in frame 2)
  task automatic run_mf(input int k, input bit esf, input bit aut,
                        input int ek, input bit frc);
    int  nfrm;
    bit  blocked;
    string lbl;
    logic [3:0] e;
    nfrm = esf ? 24 : 12;
    // boundary model at start of this multiframe
    blocked = frc || (hold_m > 0);
    if (!blocked) for (int c = 0; c < NCH; c++) slot_m[wp_m][c] = prev_m[c];
    if (!blocked) wp_m = (wp_m + 1) % 4;
    rp_m = (rp_m + 1) % 4;
    if (hold_m > 0) hold_m--;
    lbl = blocked ? "R9 replay while frozen" : (esf ? "R1 R4 nibble" : "R3 nibble");
    for (int frm = 0; frm < nfrm; frm++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          mf_start = (frm == 0 && ch == 0 && b == 0);
          rx_data = rx_bit(k, ch, frm, b, esf);
          bit_idx = 3'(b); ch_idx = 5'(ch); frm_idx = 5'(frm);
          auto_freeze_en = aut; force_freeze = frc;
          oof = (ek == 1 && frm == 2);
          carrier_loss = (ek == 2 && frm == 2);
          slip = (ek == 3 && frm == 2);
          #1;
          e = fmt(4'(slot_m[rp_m][ch]), esf);
          if (frm == 1) begin
            chk(esf ? "R2 serial bit" : "R3 serial bit", int'(sig_out),
                (b < 4) ? 0 : int'(e[7-b]));
            if (b == 7) chk(lbl, int'(sig_nib), int'(e));
            if (ch == 0 && b == 0)
              chk(frc ? "R7 forced freeze" : "R8 hold window", int'(freeze_active),
                  int'(frc || hold_m > 0));
          end
          if (frm == 2 && ch == 0 && b == 0) begin
            if (aut && ek != 0) hold_m = 3;
            chk(aut ? "R6 error freeze" : "R6 error ignored", int'(freeze_active),
                int'(frc || hold_m > 0));
          end
          if (frm == nfrm-1 && b == 7)
            chk("R5 stable within multiframe", int'(sig_nib), int'(e));
        end
      end
    end
    for (int c = 0; c < NCH; c++)
      prev_m[c] = esf ? int'(nib_val(k, c)) : int'(nib_val(k, c) & 4'hC);
  endtask

  initial begin
    tests = 0; fails = 0;
    do_reset(1'b1);
    for (int k = 0; k < 20; k++)
      run_mf(k, 1'b1, (k != 16),
             (k == 6) ? 1 : (k == 8) ? 3 : (k == 16) ? 2 : 0, (k == 13));
    do_reset(1'b0);
    for (int k = 0; k < 10; k++)
      run_mf(k, 1'b0, 1'b1, (k == 4) ? 2 : 0, (k == 8));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end
endmodule